// File: doc/BRIEF.md
# DMA Channel Control/Status Bank

This block holds one 32-bit control/status word per DMA channel, for up to 32 channels, and forms the controller's interrupt. Software writes a word to select run or stop, arm the interrupt enables and the end-of-receive actions, set or clear the compare status bit, and acknowledge event flags by writing ones to them. Software reads the word back to see the flags, the stored control bits and whether the channel's peripheral request is active right now.

The channel engines report events as one-cycle pulses on per-channel vectors. Each pulse sets the matching flag in the addressed word. Stop, end-of-receive and request-after-stop flags reach the interrupt only when their enable bit is set. Start and end flags reach it with no enable. The per-channel qualified bits form a summary word, and a single interrupt line is the OR of that word. A `run_o` bit per channel tells its engine that the channel is running.

Top module: `dma_chan_status`

## Requirements
- R1: After reset every channel word reads 0x00000008: only the stop flag (bit 3) is set, and `run_o`, `int_sum_o` and `irq_o` are zero.
- R2: A write keeps the stored flags at bits 0-4, 8-10. Writing 1 to bit 0 (bus error), bit 1 (start), bit 2 (end) or bit 9 (end-of-receive) clears that flag. Writing 1 to bit 3 (stop), bit 4 (request-after-stop), bit 8 or bit 10 (compare) leaves that bit unchanged.
- R3: A write loads bits 31-26 and bit 23 from the written value. Bits 5-7, 11-22, 24 and 25 always read as zero.
- R4: A write with bit 31 (run) set clears the stop flag. `run_o[c]` is high exactly when channel c holds run set and stop clear.
- R5: A write with neither bit 31 nor bit 22 (mask-run) set forces the stop flag to 1. A write with only bit 22 of the two set leaves the stop flag unchanged.
- R6: Writing 1 to bit 24 clears the compare flag (bit 10). Writing 1 to bit 25 sets it. If both bits are written as 1, the compare flag ends up set.
- R7: The read data `rdata_o` is combinational from `addr_i`. Bit 8 of the read data equals `req_active_i` of the addressed channel. An address at or above the channel count reads as zero.
- R8: Event pulses set flags in the next cycle: bus error sets bit 0, start sets bit 1, end sets bit 2, stop sets bit 3, request-after-stop sets bit 4, end-of-receive sets bit 9. An event in the same cycle as a write that would clear the flag wins.
- R9: Bit c of `int_sum_o` is (stop AND bit 29) OR (end-of-receive AND bit 28) OR (request-after-stop AND bit 23) OR start OR end. The bus error flag never contributes.
- R10: `irq_o` is high exactly when `int_sum_o` is nonzero.
- R11: A write or event aimed at one channel leaves every other channel's word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | CH_W | Channel index for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed channel |
| req_active_i | input | NUM_CH | Live peripheral request per channel |
| ev_buserr_i | input | NUM_CH | Bus error event pulses |
| ev_start_i | input | NUM_CH | Descriptor start event pulses |
| ev_end_i | input | NUM_CH | Transfer end event pulses |
| ev_stop_i | input | NUM_CH | Channel stopped event pulses |
| ev_ras_i | input | NUM_CH | Request-after-stop event pulses |
| ev_eor_i | input | NUM_CH | End-of-receive event pulses |
| run_o | output | NUM_CH | Channel running (run set, stop clear) |
| int_sum_o | output | NUM_CH | Qualified interrupt bit per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench uses a four-channel build and sweeps 4096 write words. Each word varies all ten control bits together, so every combination of run and mask-run is seen with every combination of the enables and the compare set/clear pair. Each word also carries ones on the acknowledge bits, on the non-clearable flag bits and on reserved bits. These separate correct W1C behaviour from over-clearing and from storing reserved bits.

Before each write, a different mix of event pulses and request levels is applied to a rotating channel. This shows whether every flag is set, qualified and reported through the right enable, and whether the other channels stay untouched. Directed cases cover the reset state and an event colliding with its own acknowledge. Further directed cases cover the mask-run hold of the stop flag, and an out-of-range address in a second build with six channels.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int unsigned B_BUSERR = 0;
  localparam int unsigned B_START  = 1;
  localparam int unsigned B_DONE   = 2;
  localparam int unsigned B_STOP   = 3;
  localparam int unsigned B_RAS    = 4;
  localparam int unsigned B_REQ    = 8;
  localparam int unsigned B_EOR    = 9;
  localparam int unsigned B_CMP    = 10;
  localparam int unsigned B_MRUN   = 22;
  localparam int unsigned B_RAS_EN = 23;
  localparam int unsigned B_CMPCLR = 24;
  localparam int unsigned B_CMPSET = 25;
  localparam int unsigned B_EOR_EN = 28;
  localparam int unsigned B_STP_EN = 29;
  localparam int unsigned B_RUN    = 31;

  localparam logic [31:0] FLAG_KEEP = 32'h0000_071F;
  localparam logic [31:0] W1C_MASK  = 32'h0000_0207;
  localparam logic [31:0] CTRL_LOAD = 32'hFC80_0000;
  localparam logic [31:0] RST_WORD  = 32'h0000_0008;

  typedef struct packed {
    logic rx_end;
    logic ras;
    logic halt;
    logic done;
    logic start;
    logic buserr;
  } ch_ev_t;

  function automatic logic [31:0] csr_merge(input logic [31:0] cur, input logic [31:0] wd);
    logic [31:0] r;
    r = (cur & FLAG_KEEP & ~(wd & W1C_MASK)) | (wd & CTRL_LOAD);
    if (wd[B_RUN]) r[B_STOP] = 1'b0;
    if (!wd[B_RUN] && !wd[B_MRUN]) r[B_STOP] = 1'b1;
    if (wd[B_CMPCLR]) r[B_CMP] = 1'b0;
    if (wd[B_CMPSET]) r[B_CMP] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_sel_i,
  input  logic [31:0] wdata_i,
  input  ch_ev_t      ev_i,
  output logic [31:0] state_o,
  output logic        run_o,
  output logic        int_o
);
  logic [31:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_sel_i) state_d = csr_merge(state_q, wdata_i);
    // events override a same-cycle acknowledge
    if (ev_i.buserr) state_d[B_BUSERR] = 1'b1;
    if (ev_i.start)  state_d[B_START]  = 1'b1;
    if (ev_i.done)   state_d[B_DONE]   = 1'b1;
    if (ev_i.halt)   state_d[B_STOP]   = 1'b1;
    if (ev_i.ras)    state_d[B_RAS]    = 1'b1;
    if (ev_i.rx_end) state_d[B_EOR]    = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RST_WORD;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign run_o   = state_q[B_RUN] & ~state_q[B_STOP];
  assign int_o   = (state_q[B_STP_EN] & state_q[B_STOP])
                 | (state_q[B_EOR_EN] & state_q[B_EOR])
                 | (state_q[B_RAS_EN] & state_q[B_RAS])
                 | state_q[B_START] | state_q[B_DONE];
endmodule

// File: rtl/dma_csr_rd_mux.sv
module dma_csr_rd_mux
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CH_W   = 5
) (
  input  logic [NUM_CH-1:0][31:0] state_i,
  input  logic [NUM_CH-1:0]       req_i,
  input  logic [CH_W-1:0]         addr_i,
  output logic [31:0]             rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (32'(addr_i) == i) begin
        rdata_o = state_i[i];
        rdata_o[B_REQ] = req_i[i];
      end
    end
  end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] req_active_i,
  input  logic [NUM_CH-1:0] ev_buserr_i,
  input  logic [NUM_CH-1:0] ev_start_i,
  input  logic [NUM_CH-1:0] ev_end_i,
  input  logic [NUM_CH-1:0] ev_stop_i,
  input  logic [NUM_CH-1:0] ev_ras_i,
  input  logic [NUM_CH-1:0] ev_eor_i,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] int_sum_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0][31:0] ch_state;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ch_ev_t ev;
    logic   sel;
    assign ev = '{rx_end: ev_eor_i[c], ras: ev_ras_i[c], halt: ev_stop_i[c],
                  done: ev_end_i[c], start: ev_start_i[c], buserr: ev_buserr_i[c]};
    assign sel = wr_en_i && (32'(addr_i) == c);

    dma_csr_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_sel_i (sel),
      .wdata_i  (wdata_i),
      .ev_i     (ev),
      .state_o  (ch_state[c]),
      .run_o    (run_o[c]),
      .int_o    (int_sum_o[c])
    );
  end

  dma_csr_rd_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rd (
    .state_i (ch_state),
    .req_i   (req_active_i),
    .addr_i  (addr_i),
    .rdata_o (rdata_o)
  );

  assign irq_o = |int_sum_o;
endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CH_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [CH_W-1:0]   addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] req_active_i,
  input logic [NUM_CH-1:0] ev_buserr_i,
  input logic [NUM_CH-1:0] ev_start_i,
  input logic [NUM_CH-1:0] ev_end_i,
  input logic [NUM_CH-1:0] ev_stop_i,
  input logic [NUM_CH-1:0] ev_ras_i,
  input logic [NUM_CH-1:0] ev_eor_i,
  input logic [NUM_CH-1:0] run_o,
  input logic [NUM_CH-1:0] int_sum_o,
  input logic              irq_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & 32'h037F_F8E0) == 32'h0); // R3

  AST_RUN_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((run_o & ~$past(run_o)) != '0) |-> ($past(wr_en_i) && $past(wdata_i[31]))); // R4

  AST_STOP_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wdata_i[31] && !wdata_i[22] && (32'(addr_i) < NUM_CH))
      |=> !run_o[$past(addr_i)]); // R5

  AST_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_active_i == '0) |-> !rdata_o[8]); // R7

  AST_START_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_start_i != '0) |=> irq_o); // R9

  AST_END_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_end_i != '0) |=> (int_sum_o != '0)); // R9
endmodule

bind dma_chan_status dma_chan_status_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (.*);

// File: tb/tb_dma_chan_status.sv
`timescale 1ns/1ps
module tb_dma_chan_status;
  localparam int unsigned NCH = 4;
  localparam int unsigned AW  = 2;
  localparam int unsigned NB  = 6;
  localparam int unsigned BW  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            wr_en;
  logic [AW-1:0]   addr;
  logic [31:0]     wdata, rdata;
  logic [NCH-1:0]  req, e_be, e_st, e_en, e_sp, e_ra, e_eo, run, isum;
  logic            irq;

  // second build: channel count that is not a power of two
  logic            b_wr_en;
  logic [BW-1:0]   b_addr;
  logic [31:0]     b_wdata, b_rdata;
  logic [NB-1:0]   b_req, b_run, b_isum;
  logic            b_irq;

  int checks = 0, fails = 0;
  logic [31:0] model [NCH];

  dma_chan_status #(.NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .req_active_i(req), .ev_buserr_i(e_be), .ev_start_i(e_st),
    .ev_end_i(e_en), .ev_stop_i(e_sp), .ev_ras_i(e_ra), .ev_eor_i(e_eo),
    .run_o(run), .int_sum_o(isum), .irq_o(irq));

  dma_chan_status #(.NUM_CH(NB)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(b_wr_en), .addr_i(b_addr), .wdata_i(b_wdata),
    .rdata_o(b_rdata), .req_active_i(b_req), .ev_buserr_i('0), .ev_start_i('0),
    .ev_end_i('0), .ev_stop_i('0), .ev_ras_i('0), .ev_eor_i('0),
    .run_o(b_run), .int_sum_o(b_isum), .irq_o(b_irq));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_write(input logic [31:0] m, input logic [31:0] v);
    logic [31:0] r;
    r = (m & 32'h0000_071F & ~(v & 32'h0000_0207)) | (v & 32'hFC80_0000);
    if (v[31]) r[3] = 1'b0;
    if (!v[31] && !v[22]) r[3] = 1'b1;
    if (v[24]) r[10] = 1'b0;
    if (v[25]) r[10] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] m_event(input logic [31:0] m, input logic [5:0] e);
    logic [31:0] r = m;
    if (e[0]) r[0] = 1'b1;
    if (e[1]) r[1] = 1'b1;
    if (e[2]) r[2] = 1'b1;
    if (e[3]) r[3] = 1'b1;
    if (e[4]) r[4] = 1'b1;
    if (e[5]) r[9] = 1'b1;
    return r;
  endfunction

  task automatic op(input int ch, input bit do_wr, input logic [31:0] v, input logic [5:0] e);
    @(negedge clk);
    wr_en = do_wr; addr = AW'(ch); wdata = v;
    e_be = '0; e_st = '0; e_en = '0; e_sp = '0; e_ra = '0; e_eo = '0;
    e_be[ch] = e[0]; e_st[ch] = e[1]; e_en[ch] = e[2];
    e_sp[ch] = e[3]; e_ra[ch] = e[4]; e_eo[ch] = e[5];
    @(negedge clk);
    wr_en = 1'b0;
    e_be = '0; e_st = '0; e_en = '0; e_sp = '0; e_ra = '0; e_eo = '0;
    if (do_wr) model[ch] = m_write(model[ch], v);
    model[ch] = m_event(model[ch], e);
  endtask

  task automatic check_all(input string tag);
    logic [NCH-1:0] ei, er;
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] m = model[c];
      @(negedge clk);
      addr = AW'(c);
      #1;
      chk(rdata, m | (32'(req[c]) << 8), tag);
      ei[c] = (m[29] & m[3]) | (m[28] & m[9]) | (m[23] & m[4]) | m[1] | m[2];
      er[c] = m[31] & ~m[3];
    end
    chk(32'(isum), 32'(ei), "R9 summary");
    chk(32'(irq), 32'(|ei), "R10 irq");
    chk(32'(run), 32'(er), "R4 run");
  endtask

  function automatic logic [31:0] sweep_word(input int k);
    logic [31:0] v = '0;
    logic [11:0] b = 12'(k);
    v[31:22] = b[9:0];
    v[9] = b[11]; v[2] = b[10]; v[1] = b[11] ^ b[0]; v[0] = b[10] ^ b[1];
    v[3] = b[5]; v[4] = b[6]; v[10] = b[7]; v[8] = b[3]; // R2 non-clearable positions
    v[7:5] = b[4:2]; v[15:11] = b[8:4];                    // R3 reserved positions
    return v;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wr_en = 0; addr = '0; wdata = '0; req = '0;
    e_be = '0; e_st = '0; e_en = '0; e_sp = '0; e_ra = '0; e_eo = '0;
    b_wr_en = 0; b_addr = '0; b_wdata = '0; b_req = '0;
    for (int c = 0; c < NCH; c++) model[c] = 32'h8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset word, run, summary and irq
    check_all("R1 reset");

    // R2 R3 R5 R6 R8 R11: swept writes and events, all channels compared
    for (int k = 0; k < 4096; k++) begin
      int ch = (k & 3) ^ ((k >> 10) & 3);
      logic [5:0] e = 6'((k * 37) % 64);
      req = NCH'((k >> 2) ^ (k >> 6));
      op(ch, 1'b0, 32'h0, e);
      op(ch, 1'b1, sweep_word(k), 6'h0);
      check_all("R2 R3 R5 R6 R7 R8 R11 sweep");
    end

    // R8 event wins over same-cycle acknowledge
    for (int c = 0; c < NCH; c++) begin
      op(c, 1'b1, 32'h8000_0207, 6'h27);
      check_all("R8 collision");
    end

    // R5 mask-run alone keeps a cleared stop flag
    op(1, 1'b1, 32'h8000_0000, 6'h0);
    op(1, 1'b1, 32'h0040_0000, 6'h0);
    check_all("R5 mask-run");
    op(1, 1'b1, 32'h0000_0000, 6'h0);
    check_all("R5 forced stop");

    // R6 both compare bits: set wins
    op(2, 1'b1, 32'h0340_0000, 6'h0);
    check_all("R6 both");

    // R7 out-of-range address reads zero (six-channel build)
    @(negedge clk);
    b_req = '1;
    b_wr_en = 1'b1; b_addr = 3'd5; b_wdata = 32'h8000_0000;
    @(negedge clk);
    b_wr_en = 1'b0; b_addr = 3'd5;
    #1 chk(b_rdata, 32'h8000_0100, "R7 last channel");
    b_addr = 3'd6;
    #1 chk(b_rdata, 32'h0, "R7 out of range 6");
    b_addr = 3'd7;
    #1 chk(b_rdata, 32'h0, "R7 out of range 7");
    chk(32'(b_run), 32'h20, "R4 run six-channel");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule